// File: doc/BRIEF.md
# NRZI Bit-Stuffing Packet Transmitter

This block puts one packet onto a two-wire differential serial bus. A start pulse with a byte count launches a transmission. The count includes the leading sync byte. The block first takes the bus and holds it in the idle (J) state for one bit time. It then reads the bytes one after another from an external buffer, through a combinational address/data pair. Each byte is sent least significant bit first, in NRZI coding. A 0 bit toggles the line state and a 1 bit holds it.

After every six consecutive 1 bits the block inserts an extra toggle. This run count is carried from one byte into the next, and it also applies after the last bit of the packet. After the final data symbol the block drives the end-of-packet sequence: two bit times of SE0, then one bit time of J. It then releases both lines and pulses a completion flag. Every symbol lasts a fixed number of clocks, and the next byte is read at the boundary where it is needed, so no gaps appear between bytes. A two-byte packet (sync followed by a PID) forms a handshake reply.

Top module: `nrzi_tx`

## Requirements
- R1: After reset, oe, dp, dm, busy and tx_done are all 0.
- R2: In the clock cycle after start is sampled in the idle state, oe and busy are 1 and the bus shows J (dp=0, dm=1). J is held for exactly one bit time (8 clocks) before the first data symbol.
- R3: Buffer bytes are read at rd_addr 0, 1, ... N-1, where N is byte_cnt. Each byte is sent bit 0 first, and every symbol lasts exactly 8 clocks with no gap between bytes. For a packet of S driven symbols (lead J, data and stuffed symbols, EOP), tx_done is high in the cycle 8*S+1 cycles after the start edge.
- R4: Line states are J = (dp=0, dm=1) and K = (dp=1, dm=0). A data bit of 0 changes the state from the previous symbol, and a data bit of 1 keeps it. The sync byte 0x80 therefore starts as KJKJKJKK after the lead J.
- R5: After six consecutive data 1 bits, one extra symbol with toggled state is inserted and the run count restarts. The run continues across byte boundaries and is also completed after the last byte, before the EOP.
- R6: After the last data or stuffed symbol, the bus shows SE0 (dp=0, dm=0) for 16 clocks, then J for 8 clocks, then oe goes to 0.
- R7: tx_done is a one-cycle pulse in the first cycle with oe=0. busy is high from the cycle after start through the last J cycle of the EOP.
- R8: A start pulse while busy is ignored. The packet in flight continues unchanged and finishes at its own time.
- R9: dp and dm are never both 1. While oe is 0, both dp and dm are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 8 clocks per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a packet when idle |
| byte_cnt | input | 8 | Number of bytes to send, sync byte included |
| rd_addr | output | 8 | Buffer index of the byte to read |
| rd_data | input | 8 | Buffer byte at rd_addr (combinational) |
| dp | output | 1 | Drive level of the positive line |
| dm | output | 1 | Drive level of the negative line |
| oe | output | 1 | Output enable of both lines |
| busy | output | 1 | Transmission in progress |
| tx_done | output | 1 | One-cycle pulse after the bus is released |

## Verification
A single bit boundary can need two things at once: fetching a new byte and inserting a stuffed toggle. This happens when a run of six 1 bits ends exactly on the last bit of a byte. The stuff must win, and the fetch must wait one symbol. The bench provokes this with a byte whose upper six bits are 1, followed by more bytes. In another case the run ends exactly on the last byte, so the stuff competes with the start of the EOP. In each case the full symbol sequence is compared against a model built independently in the bench, and the tx_done cycle count is checked too, so a lost or doubled symbol shows up as both a sequence and a timing error.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_DATA,
    PH_SE0,
    PH_TAIL
  } phase_t;

  // NRZI: a 0 bit flips the line, a 1 bit keeps it (line_j=1 means J)
  function automatic logic nrzi_next(input logic line_j, input logic data_bit);
    return data_bit ? line_j : ~line_j;
  endfunction

  // {dp, dm} for a phase and line state
  function automatic logic [1:0] drive_pair(input phase_t ph, input logic line_j);
    case (ph)
      PH_LEAD, PH_DATA, PH_TAIL: return line_j ? 2'b01 : 2'b10;
      default:                   return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/nrzi_tx_timer.sv
module nrzi_tx_timer #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bit_end
);
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign bit_end = run && (cnt_q == LAST);
endmodule

// File: rtl/nrzi_tx_feeder.sv
module nrzi_tx_feeder #(
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  cnt_in,
  input  logic              step,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cur_bit,
  output logic              empty,
  output logic              fetch_evt
);
  logic [7:0]       shreg_q;
  logic [3:0]       bits_left_q;
  logic [LEN_W-1:0] bytes_left_q;
  logic [ADDR_W-1:0] addr_q;
  logic             need_byte;

  assign need_byte = (bits_left_q == 4'd0);
  assign cur_bit   = need_byte ? rd_data[0] : shreg_q[0];
  assign empty     = need_byte && (bytes_left_q == '0);
  assign fetch_evt = step && need_byte;
  assign rd_addr   = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q      <= '0;
      bits_left_q  <= '0;
      bytes_left_q <= '0;
      addr_q       <= '0;
    end else if (load) begin
      shreg_q      <= '0;
      bits_left_q  <= '0;
      bytes_left_q <= cnt_in;
      addr_q       <= '0;
    end else if (step) begin
      if (need_byte) begin
        shreg_q      <= {1'b0, rd_data[7:1]};
        bits_left_q  <= 4'd7;
        bytes_left_q <= bytes_left_q - 1'b1;
        addr_q       <= addr_q + 1'b1;
      end else begin
        shreg_q     <= {1'b0, shreg_q[7:1]};
        bits_left_q <= bits_left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/nrzi_tx_encoder.sv
module nrzi_tx_encoder
  import nrzi_tx_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic emit,
  input  logic stuff,
  input  logic force_j,
  input  logic bit_in,
  output logic line_j,
  output logic stuff_due
);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam logic [ONES_W-1:0] RUN_MAX = ONES_W'(STUFF_RUN);

  logic [ONES_W-1:0] ones_q;

  assign stuff_due = (ones_q == RUN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_j <= 1'b1;
      ones_q <= '0;
    end else if (init || force_j) begin
      line_j <= 1'b1;
      ones_q <= '0;
    end else if (stuff) begin
      line_j <= ~line_j;
      ones_q <= '0;
    end else if (emit) begin
      line_j <= nrzi_next(line_j, bit_in);
      ones_q <= bit_in ? ones_q + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/nrzi_tx.sv
module nrzi_tx
  import nrzi_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int LEN_W        = 8,
  parameter int ADDR_W       = 8,
  parameter int STUFF_RUN    = 6,
  parameter int EOP_SE0_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  byte_cnt,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              dp,
  output logic              dm,
  output logic              oe,
  output logic              busy,
  output logic              tx_done
);
  localparam int SE0_W = (EOP_SE0_BITS > 1) ? $clog2(EOP_SE0_BITS) : 1;
  localparam logic [SE0_W-1:0] SE0_LAST = SE0_W'(EOP_SE0_BITS - 1);

  phase_t           phase_q;
  logic [SE0_W-1:0] se0_q;
  logic             accept, bit_end, line_j, stuff_due;
  logic             cur_bit, empty, fetch_evt;
  logic             in_stream, stuff_evt, data_evt, end_evt, tail_evt;

  assign busy   = (phase_q != PH_IDLE);
  assign accept = (phase_q == PH_IDLE) && start;

  // boundary events, named for the checker
  assign in_stream = (phase_q == PH_LEAD) || (phase_q == PH_DATA);
  assign stuff_evt = bit_end && (phase_q == PH_DATA) && stuff_due;
  assign end_evt   = bit_end && in_stream && !stuff_evt && empty;
  assign data_evt  = bit_end && in_stream && !stuff_evt && !empty;
  assign tail_evt  = bit_end && (phase_q == PH_SE0) && (se0_q == SE0_LAST);

  nrzi_tx_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .bit_end(bit_end)
  );

  nrzi_tx_feeder #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_feeder (
    .clk(clk), .rst_n(rst_n), .load(accept), .cnt_in(byte_cnt),
    .step(data_evt), .rd_data(rd_data), .rd_addr(rd_addr),
    .cur_bit(cur_bit), .empty(empty), .fetch_evt(fetch_evt)
  );

  nrzi_tx_encoder #(.STUFF_RUN(STUFF_RUN)) u_enc (
    .clk(clk), .rst_n(rst_n), .init(accept), .emit(data_evt),
    .stuff(stuff_evt), .force_j(tail_evt), .bit_in(cur_bit),
    .line_j(line_j), .stuff_due(stuff_due)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      se0_q   <= '0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= bit_end && (phase_q == PH_TAIL);
      case (phase_q)
        PH_IDLE: if (accept) phase_q <= PH_LEAD;
        PH_LEAD, PH_DATA: begin
          if (end_evt) begin
            phase_q <= PH_SE0;
            se0_q   <= '0;
          end else if (bit_end) begin
            phase_q <= PH_DATA;
          end
        end
        PH_SE0: begin
          if (tail_evt)     phase_q <= PH_TAIL;
          else if (bit_end) se0_q   <= se0_q + 1'b1;
        end
        PH_TAIL: if (bit_end) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign {dp, dm} = drive_pair(phase_q, line_j);
  assign oe       = busy;
endmodule

// File: rtl/nrzi_tx_chk.sv
module nrzi_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic oe,
  input logic dp,
  input logic dm,
  input logic tx_done,
  input logic bit_end,
  input logic stuff_evt
);
  AST_NO_SE1: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp && dm)); // R9

  AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!dp && !dm)); // R9

  AST_SYMBOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bit_end)) |-> $stable({dp, dm})); // R3

  AST_STUFF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_evt |=> (dp != $past(dp))); // R5

  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!oe && $past(oe))); // R7

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !bit_end) |=> busy); // R8
endmodule

bind nrzi_tx nrzi_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .oe(oe),
  .dp(dp), .dm(dm), .tx_done(tx_done), .bit_end(bit_end),
  .stuff_evt(stuff_evt)
);

// File: tb/nrzi_tx_bench.sv
module nrzi_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] byte_cnt = '0;
  logic [7:0] rd_addr, rd_data;
  logic       dp, dm, oe, busy, tx_done;
  logic [7:0] mem [16];

  int checks = 0;
  int failures = 0;

  localparam logic [1:0] SYM_J = 2'b01, SYM_K = 2'b10, SYM_SE0 = 2'b00;

  always #4 clk = ~clk;
  assign rd_data = mem[rd_addr[3:0]];

  nrzi_tx u_nrzi_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
    .rd_addr(rd_addr), .rd_data(rd_data), .dp(dp), .dm(dm), .oe(oe),
    .busy(busy), .tx_done(tx_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected symbol list from the requirements (R2, R4, R5, R6)
  task automatic build_expected(input int n, ref logic [1:0] q[$]);
    bit line = 1'b1;
    int ones = 0;
    q.delete();
    q.push_back(SYM_J);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        bit b = mem[i][k];
        if (!b) line = !line;
        q.push_back(line ? SYM_J : SYM_K);
        ones = b ? ones + 1 : 0;
        if (ones == 6) begin
          line = !line;
          q.push_back(line ? SYM_J : SYM_K);
          ones = 0;
        end
      end
    end
    q.push_back(SYM_SE0);
    q.push_back(SYM_SE0);
    q.push_back(SYM_J);
  endtask

  // send a packet; inj >= 0 pulses start again during symbol inj
  task automatic run_packet(input string req, input int n, input int inj);
    logic [1:0] exp_q[$];
    logic [1:0] got[$];
    int s, bad_idx;
    bit se1_seen = 1'b0;
    build_expected(n, exp_q);
    s = exp_q.size();
    @(negedge clk);
    start = 1'b1;
    byte_cnt = 8'(n);
    @(negedge clk);
    start = 1'b0;
    byte_cnt = 8'd3;
    check(oe && busy && {dp, dm} == SYM_J, "R2 lead J",
          {oe, busy, dp, dm}, {2'b11, SYM_J});
    repeat (4) @(negedge clk);
    for (int k = 0; k < s; k++) begin
      got.push_back({dp, dm});
      if (dp && dm) se1_seen = 1'b1;
      if (k == s - 1) break;
      if (k == inj) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
    end
    bad_idx = -1;
    for (int k = 0; k < s; k++)
      if (bad_idx < 0 && got[k] !== exp_q[k]) bad_idx = k;
    check(bad_idx < 0, req, (bad_idx < 0) ? 0 : int'(got[bad_idx]),
          (bad_idx < 0) ? 0 : int'(exp_q[bad_idx]));
    check(got[s-3] == SYM_SE0 && got[s-2] == SYM_SE0 && got[s-1] == SYM_J,
          "R6 EOP shape", {got[s-3], got[s-2], got[s-1]}, {SYM_SE0, SYM_SE0, SYM_J});
    check(!se1_seen, "R9 no SE1", se1_seen, 0);
    // now at cycle 8(s-1)+4 of 8s; move to last driven cycle
    repeat (3) @(negedge clk);
    check(oe && busy && !tx_done, "R7 busy through tail",
          {oe, busy, tx_done}, 3'b110);
    @(negedge clk);
    check(!oe && !busy && tx_done && !dp && !dm, "R3 R7 done timing",
          {oe, busy, tx_done, dp, dm}, 5'b00100);
    @(negedge clk);
    check(!tx_done && !oe, "R7 single pulse", {tx_done, oe}, 0);
  endtask

  task automatic t_reset;
    check(!oe && !dp && !dm && !busy && !tx_done, "R1 reset",
          {oe, dp, dm, busy, tx_done}, 0);
  endtask

  task automatic t_handshake;
    mem[0] = 8'h80; mem[1] = 8'hD2;
    run_packet("R4 R3 handshake", 2, -1);
  endtask

  task automatic t_cross_byte;
    // byte 1 bits 2..7 are 1: the stuff falls on the byte's last boundary
    mem[0] = 8'h80; mem[1] = 8'hFC; mem[2] = 8'hFF; mem[3] = 8'h01;
    run_packet("R5 stuff across bytes", 4, -1);
  endtask

  task automatic t_stuff_at_end;
    mem[0] = 8'h80; mem[1] = 8'h00; mem[2] = 8'hFC;
    run_packet("R5 stuff before EOP", 3, -1);
  endtask

  task automatic t_mixed;
    mem[0] = 8'h80; mem[1] = 8'hA5; mem[2] = 8'h3C; mem[3] = 8'h7E; mem[4] = 8'h00;
    run_packet("R3 R4 mixed data", 5, -1);
  endtask

  task automatic t_busy_ignore;
    mem[0] = 8'h80; mem[1] = 8'h5A; mem[2] = 8'hFF;
    run_packet("R8 start while busy", 3, 6);
  endtask

  task automatic t_idle_quiet;
    repeat (20) @(negedge clk);
    check(!oe && !dp && !dm && !busy, "R9 released low when idle",
          {oe, dp, dm, busy}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_handshake();
    t_cross_byte();
    t_stuff_at_end();
    t_mixed();
    t_busy_ignore();
    t_idle_quiet();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule